// File: doc/BRIEF.md
# ADC Conversion Sequencer with Threshold Compare

This block is the digital control side of a successive-approximation converter. It runs entirely on the peripheral clock. A programmable divider turns that clock into a single-cycle ADC clock-enable strobe. A conversion request can come from a software start strobe or from a trigger input. The request is aligned to the next ADC clock strobe. The block then counts the conversion latency in ADC clocks. The latency depends on the selected resolution and gain range.

When the count ends, the block captures a result word from a behavioural sample input and pulses done. It then raises an event pulse and a sticky interrupt flag. This happens on every conversion, or only when the result lies strictly above or strictly below a programmable 12-bit threshold.

One request that arrives during a conversion is held. That request starts a new conversion on the same ADC clock edge that completes the current one.

Top module: `adc_seq`

## Requirements
- R1: After reset, `busy_o`, `done_o`, `evt_o` and `irq_flag_o` are 0 and `result_o` is 0.
- R2: Prescaler code n on `presc_sel_i` gives one ADC clock strobe every 2^(n+2) peripheral cycles (4 to 512). The divider counter is held at zero while `enable_i` is 0, so the first strobe falls on the 2^(n+2)-th rising edge with `enable_i` high.
- R3: The conversion lasts 1 + RES/2 + X ADC clocks. RES is 12 when `res_12b_i`=1 and 8 otherwise. X comes from `gain_sel_i`: code 0 (1x) gives 0; codes 1 and 2 (2x, 4x) give 1; codes 3 and 4 (8x, 16x) give 2; codes 5, 6 and 7 (32x, 64x, reserved) give 3.
- R4: A one-cycle pulse on either `sw_start_i` or `evt_start_i` requests a conversion.
- R5: A request must be registered at least one peripheral cycle before the ADC strobe that starts the conversion. A request that is present only in the strobe cycle waits for the following strobe.
- R6: At completion, `result_o` takes `sample_i` in 12-bit mode. In 8-bit mode it takes `sample_i[11:4]` in bits 7:0, with bits 11:8 zero. `done_o` pulses for one cycle in the first cycle that shows the new result.
- R7: With `cmp_en_i`=0, `evt_o` pulses together with `done_o` and `irq_flag_o` is set, on every conversion.
- R8: With `cmp_en_i`=1, the event and flag occur only when the result is strictly greater than `cmp_thr_i` (`cmp_above_i`=1) or strictly less than it (`cmp_above_i`=0). `done_o` still pulses.
- R9: `irq_flag_o` stays set until `flag_clr_i` is 1 for a cycle. A new hit in that same cycle keeps it set.
- R10: A request that arrives while busy is held, one deep. The new conversion starts on the completion strobe of the current one, so the next done comes L ADC clocks later. Further requests in that time are dropped.
- R11: Driving `enable_i` low aborts a running conversion, drops a held request and produces no done. `result_o` keeps its last value.
- R12: `busy_o` rises on the starting strobe and falls on the completing strobe, unless a held request restarts the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enable; low clears divider and control |
| presc_sel_i | input | PSEL_W | Divider code n, ratio 2^(n+2) |
| res_12b_i | input | 1 | 1 = 12-bit, 0 = 8-bit conversion |
| gain_sel_i | input | 3 | Gain range code (see R3) |
| sw_start_i | input | 1 | Software start strobe |
| evt_start_i | input | 1 | Trigger input start strobe |
| sample_i | input | DATA_W | Behavioural converter data |
| cmp_en_i | input | 1 | Threshold-gated reporting enable |
| cmp_above_i | input | 1 | 1 = report above threshold, 0 = below |
| cmp_thr_i | input | DATA_W | Threshold value |
| flag_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DATA_W | Captured result |
| evt_o | output | 1 | One-cycle event on a reported completion |
| irq_flag_o | output | 1 | Sticky interrupt flag |

## Verification
The bench builds the block with DATA_W=12 and PSEL_W=3. With these values the divider counter is 9 bits wide, so every ratio from 4 to 512 can be reached, including the slowest code 7. The vector table covers both resolutions, all four gain bands (the reserved code among them) and both compare directions, including the equal-to-threshold case. Each vector checks the exact number of peripheral cycles from enable to done. Directed runs cover a request that lands in the strobe cycle itself, a held request that restarts the block back to back, a dropped extra request, and an abort by disable.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned GAIN_W = 3;
  localparam int unsigned LAT_W  = 4;
  localparam int unsigned RES_LO = 8;

  // extra ADC clocks contributed by the gain range code
  function automatic int unsigned gain_extra(input logic [GAIN_W-1:0] g);
    if (g == '0)      return 0;
    else if (g >= 3'd5) return 3;
    else if (g >= 3'd3) return 2;
    else              return 1;
  endfunction

  function automatic logic [LAT_W-1:0] conv_latency(input logic hi_res,
                                                    input logic [GAIN_W-1:0] g,
                                                    input int unsigned res_hi);
    int unsigned l;
    l = 1 + (hi_res ? res_hi / 2 : RES_LO / 2) + gain_extra(g);
    return LAT_W'(l);
  endfunction
endpackage

// File: rtl/adc_presc.sv
module adc_presc #(
  parameter int unsigned PSEL_W = 3,
  localparam int unsigned CNT_W = (1 << PSEL_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [PSEL_W-1:0] sel_i,
  output logic              tick_o
);
  logic [CNT_W-1:0] cnt_q, mask;

  for (genvar b = 0; b < CNT_W; b++) begin : g_mask
    assign mask[b] = (int'(sel_i) + 2 > b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && ((cnt_q & mask) == mask);

  assert_tick_spacing_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/adc_start_sync.sv
module adc_start_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic req_i,
  input  logic take_i,
  output logic pend_o
);
  // single-entry request latch; a fresh request in the take cycle survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pend_o <= 1'b0;
    else if (!en_i) pend_o <= 1'b0;
    else            pend_o <= (pend_o && !take_i) || req_i;
  end

  assert_take_needs_pend_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |-> pend_o);
endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              pend_i,
  input  logic              res_12b_i,
  input  logic [GAIN_W-1:0] gain_sel_i,
  input  logic [DATA_W-1:0] sample_i,
  output logic              take_o,
  output logic              cmpl_o,
  output logic [DATA_W-1:0] cap_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o
);
  localparam int unsigned SHIFT = DATA_W - RES_LO;

  logic [LAT_W-1:0] rem_q;
  logic             res_q;
  logic             last;

  assign last   = busy_o && tick_i && (rem_q == LAT_W'(1));
  assign cmpl_o = last;
  assign take_o = tick_i && pend_i && (!busy_o || last);
  assign cap_o  = res_q ? sample_i : (sample_i >> SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o   <= 1'b0;
      rem_q    <= '0;
      res_q    <= 1'b0;
      done_o   <= 1'b0;
      result_o <= '0;
    end else if (!en_i) begin
      busy_o <= 1'b0;
      rem_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= last;
      if (last) result_o <= cap_o;
      if (take_o) begin
        busy_o <= 1'b1;
        rem_q  <= conv_latency(res_12b_i, gain_sel_i, DATA_W);
        res_q  <= res_12b_i;
      end else if (last) begin
        busy_o <= 1'b0;
        rem_q  <= '0;
      end else if (busy_o && tick_i) begin
        rem_q <= rem_q - 1'b1;
      end
    end
  end

  assert_rem_live_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> rem_q != '0);
  assert_done_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_after_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $past(busy_o));
endmodule

// File: rtl/adc_cmp.sv
module adc_cmp #(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmpl_i,
  input  logic [DATA_W-1:0] cap_i,
  input  logic              cmp_en_i,
  input  logic              cmp_above_i,
  input  logic [DATA_W-1:0] thr_i,
  input  logic              clr_i,
  output logic              evt_o,
  output logic              flag_o
);
  logic cond, hit;

  always_comb begin
    if (!cmp_en_i)        cond = 1'b1;
    else if (cmp_above_i) cond = cap_i > thr_i;
    else                  cond = cap_i < thr_i;
  end
  assign hit = cmpl_i && cond;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o  <= 1'b0;
      flag_o <= 1'b0;
    end else begin
      evt_o <= hit;
      if (hit)        flag_o <= 1'b1;
      else if (clr_i) flag_o <= 1'b0;
    end
  end

  assert_evt_sets_flag_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> flag_o);
  assert_flag_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_o && !clr_i) |=> flag_o);
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned PSEL_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic [PSEL_W-1:0] presc_sel_i,
  input  logic              res_12b_i,
  input  logic [GAIN_W-1:0] gain_sel_i,
  input  logic              sw_start_i,
  input  logic              evt_start_i,
  input  logic [DATA_W-1:0] sample_i,
  input  logic              cmp_en_i,
  input  logic              cmp_above_i,
  input  logic [DATA_W-1:0] cmp_thr_i,
  input  logic              flag_clr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] result_o,
  output logic              evt_o,
  output logic              irq_flag_o
);
  logic              tick, pend, take, cmpl;
  logic [DATA_W-1:0] cap;

  adc_presc #(.PSEL_W(PSEL_W)) u_presc (
    .clk_i, .rst_ni, .en_i(enable_i), .sel_i(presc_sel_i), .tick_o(tick)
  );

  adc_start_sync u_start (
    .clk_i, .rst_ni, .en_i(enable_i), .req_i(sw_start_i || evt_start_i),
    .take_i(take), .pend_o(pend)
  );

  adc_conv_ctl #(.DATA_W(DATA_W)) u_ctl (
    .clk_i, .rst_ni, .en_i(enable_i), .tick_i(tick), .pend_i(pend),
    .res_12b_i, .gain_sel_i, .sample_i, .take_o(take), .cmpl_o(cmpl),
    .cap_o(cap), .busy_o, .done_o, .result_o
  );

  adc_cmp #(.DATA_W(DATA_W)) u_cmp (
    .clk_i, .rst_ni, .cmpl_i(cmpl), .cap_i(cap), .cmp_en_i, .cmp_above_i,
    .thr_i(cmp_thr_i), .clr_i(flag_clr_i), .evt_o, .flag_o(irq_flag_o)
  );

  assert_start_on_tick_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tick && pend));
  assert_evt_with_done_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> done_o);
  assert_above_strict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $past(cmp_en_i && cmp_above_i)) |-> result_o > $past(cmp_thr_i));
  assert_below_strict_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && $past(cmp_en_i && !cmp_above_i)) |-> result_o < $past(cmp_thr_i));
  assert_disable_idles_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !busy_o && !done_o);
endmodule

// File: tb/adc_seq_test.sv
module adc_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [2:0]  presc = '0;
  logic        r12 = 1'b0;
  logic [2:0]  gain = '0;
  logic        sw = 1'b0, ev = 1'b0;
  logic [11:0] smp = '0;
  logic        ce = 1'b0, ab = 1'b0;
  logic [11:0] thr = '0;
  logic        clr = 1'b0;
  logic        busy, done, evt, flag;
  logic [11:0] result;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  adc_seq uut (
    .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .presc_sel_i(presc),
    .res_12b_i(r12), .gain_sel_i(gain), .sw_start_i(sw), .evt_start_i(ev),
    .sample_i(smp), .cmp_en_i(ce), .cmp_above_i(ab), .cmp_thr_i(thr),
    .flag_clr_i(clr), .busy_o(busy), .done_o(done), .result_o(result),
    .evt_o(evt), .irq_flag_o(flag)
  );

  typedef struct packed {
    logic [2:0]  ps;
    logic        r12;
    logic [2:0]  g;
    logic [11:0] smp;
    logic        ce;
    logic        ab;
    logic [11:0] thr;
    logic        use_ev;
    logic [11:0] res;
    int          cyc;
    logic        hit;
  } vec_t;

  // cyc = 2^(ps+2) * (L + 1), L = 1 + RES/2 + extra
  localparam vec_t VECS [12] = '{
    '{3'd0, 1'b0, 3'd0, 12'hABC, 1'b0, 1'b0, 12'h000, 1'b0, 12'h0AB,   24, 1'b1},
    '{3'd0, 1'b1, 3'd0, 12'hABC, 1'b0, 1'b0, 12'h000, 1'b1, 12'hABC,   32, 1'b1},
    '{3'd1, 1'b1, 3'd1, 12'h123, 1'b0, 1'b0, 12'h000, 1'b1, 12'h123,   72, 1'b1},
    '{3'd0, 1'b0, 3'd3, 12'hFF0, 1'b0, 1'b0, 12'h000, 1'b0, 12'h0FF,   32, 1'b1},
    '{3'd0, 1'b1, 3'd6, 12'h555, 1'b0, 1'b0, 12'h000, 1'b0, 12'h555,   44, 1'b1},
    '{3'd2, 1'b1, 3'd5, 12'h800, 1'b1, 1'b1, 12'h7FF, 1'b0, 12'h800,  176, 1'b1},
    '{3'd0, 1'b1, 3'd0, 12'h7FF, 1'b1, 1'b1, 12'h7FF, 1'b1, 12'h7FF,   32, 1'b0},
    '{3'd0, 1'b1, 3'd0, 12'h100, 1'b1, 1'b0, 12'h200, 1'b0, 12'h100,   32, 1'b1},
    '{3'd0, 1'b1, 3'd0, 12'h300, 1'b1, 1'b0, 12'h200, 1'b0, 12'h300,   32, 1'b0},
    '{3'd7, 1'b0, 3'd2, 12'h4F0, 1'b0, 1'b0, 12'h000, 1'b1, 12'h04F, 3584, 1'b1},
    '{3'd0, 1'b0, 3'd4, 12'h0FF, 1'b1, 1'b1, 12'h00E, 1'b0, 12'h00F,   32, 1'b1},
    '{3'd3, 1'b0, 3'd7, 12'h200, 1'b1, 1'b0, 12'h020, 1'b0, 12'h020,  288, 1'b0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one cycle with enable low, then enable with optional start; counts rising edges
  task automatic restart(input logic start, input logic use_ev);
    @(negedge clk); enable = 1'b0;
    @(negedge clk); enable = 1'b1;
    if (start) begin
      if (use_ev) ev = 1'b1; else sw = 1'b1;
    end
  endtask

  task automatic wait_done(inout int n);
    int guard = 0;
    forever begin
      @(posedge clk); n++;
      @(negedge clk); sw = 1'b0; ev = 1'b0;
      if (done) break;
      guard++;
      if (guard > 6000) begin
        chk("watchdog wait_done", 0, 1);
        break;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    logic [11:0] held;
    #1;
    // R1 reset state
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 evt", evt, 0);
    chk("R1 flag", flag, 0);
    chk("R1 result", result, 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // vector table: R2 R3 R4 R6 R7 R8 R9
    foreach (VECS[i]) begin
      presc = VECS[i].ps; r12 = VECS[i].r12; gain = VECS[i].g; smp = VECS[i].smp;
      ce = VECS[i].ce; ab = VECS[i].ab; thr = VECS[i].thr;
      restart(1'b1, VECS[i].use_ev);
      n = 0;
      wait_done(n);
      chk($sformatf("R2/R3/R4 latency vec%0d", i), n, VECS[i].cyc);
      chk($sformatf("R6 result vec%0d", i), result, VECS[i].res);
      chk($sformatf("R7/R8 evt vec%0d", i), evt, VECS[i].hit);
      chk($sformatf("R7/R8 flag vec%0d", i), flag, VECS[i].hit);
      @(negedge clk);
      chk($sformatf("R6 done single vec%0d", i), done, 0);
      chk($sformatf("R12 busy low vec%0d", i), busy, 0);
      if (VECS[i].hit) begin
        repeat (4) @(negedge clk);
        chk($sformatf("R9 flag holds vec%0d", i), flag, 1);
      end
      clr = 1'b1;
      @(negedge clk); clr = 1'b0;
      chk($sformatf("R9 flag cleared vec%0d", i), flag, 0);
    end

    // R5 late request: start present only in strobe cycle (P=4, L=7)
    presc = 3'd0; r12 = 1'b1; gain = 3'd0; ce = 1'b0; smp = 12'h321;
    restart(1'b0, 1'b0);
    n = 0;
    repeat (3) begin @(posedge clk); n++; end
    @(negedge clk); sw = 1'b1;
    @(posedge clk); n++;
    @(negedge clk); sw = 1'b0;
    chk("R5 deferred not busy", busy, 0);
    wait_done(n);
    chk("R5 deferred latency", n, 36);

    // R5 on-time request: one cycle before the strobe
    restart(1'b0, 1'b0);
    n = 0;
    repeat (2) begin @(posedge clk); n++; end
    @(negedge clk); sw = 1'b1;
    wait_done(n);
    chk("R5 on-time latency", n, 32);
    clr = 1'b1; @(negedge clk); clr = 1'b0;

    // R10 held request restarts back to back; extra request dropped
    restart(1'b1, 1'b0);
    n = 0;
    repeat (10) begin @(posedge clk); n++; end
    @(negedge clk); sw = 1'b1;
    @(posedge clk); n++;
    @(negedge clk); sw = 1'b0;
    repeat (3) begin @(posedge clk); n++; end
    @(negedge clk); ev = 1'b1;
    wait_done(n);
    chk("R10 first done", n, 32);
    chk("R10 busy across restart", busy, 1);
    wait_done(n);
    chk("R10 second done", n, 60);
    chk("R12 busy falls", busy, 0);
    n = 0;
    repeat (120) begin
      @(negedge clk);
      if (done) n++;
    end
    chk("R10 no third conversion", n, 0);
    clr = 1'b1; @(negedge clk); clr = 1'b0;

    // R11 disable aborts
    held = result;
    smp = 12'hFED;
    restart(1'b1, 1'b0);
    repeat (12) @(negedge clk);
    chk("R12 busy during conversion", busy, 1);
    enable = 1'b0; sw = 1'b1;
    @(negedge clk);
    chk("R11 busy cleared", busy, 0);
    sw = 1'b0; enable = 1'b1;
    n = 0;
    repeat (120) begin
      @(negedge clk);
      if (done || busy) n++;
    end
    chk("R11 no done after abort", n, 0);
    chk("R11 result held", result, held);
    chk("R11 flag untouched", flag, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule